// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one NAND address request into the ordered stream of address bytes that a command issuer places on the flash bus. A request carries a flag saying whether a column address is present, a flag saying whether a page (row) address is present, the page address itself, a large-page selector and the device capacity as a base-two logarithm in MiB. When `start` is pulsed while the block is idle, it captures these inputs and works out how many column bytes and row bytes the series needs. It then presents the bytes one at a time.

The output side is a valid/ready stream. `out_valid` stays high from launch until the final byte is taken. A byte counts as taken on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the byte and its `out_last` flag are held unchanged, and the next byte only appears after the current one is accepted. The issuer may hold `out_ready` low for any number of cycles.

`done` is a single-cycle pulse that tells the issuer the series has finished. The column bytes are always zero, because the issuer transfers whole pages and picks the offset afterwards. Row bytes go out least-significant first.

Top module: `nand_addr_seq`

## Requirements
- R1: With the column flag set, the series starts with one 0x00 byte for a 512-byte page, or with two 0x00 bytes when `large_page` is 1.
- R2: Row bytes follow the column bytes in the order page_addr[7:0], page_addr[15:8], and then page_addr[23:16] when a third row byte is needed.
- R3: With `large_page` = 1 and the page flag set, three row bytes are sent when `dev_log2_mib` >= 8 (capacity of at least 256 MiB), and two otherwise.
- R4: With `large_page` = 0 and the page flag set, three row bytes are sent when `dev_log2_mib` >= 6 (capacity of at least 64 MiB), and two otherwise.
- R5: `out_last` is 1 on the final byte of the series and 0 on every other byte. With only a column present on a 512-byte page, this makes the single column byte the last one.
- R6: While `out_valid` = 1 and `out_ready` = 0, `out_byte` and `out_last` hold. The series advances by exactly one byte per accepted transfer.
- R7: A start with both flags clear emits no byte and pulses `done` on the cycle after the start edge.
- R8: `done` is high for exactly one cycle, on the cycle after the final byte is accepted. `out_valid` is 0 in that cycle.
- R9: A `start` pulse that arrives while a series is in progress is ignored, so the remaining bytes are unchanged.
- R10: After reset, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a series |
| col_en | input | 1 | A column address is present |
| page_en | input | 1 | A page address is present |
| page_addr | input | 24 | Page address, captured at start |
| large_page | input | 1 | Page larger than 512 bytes |
| dev_log2_mib | input | 4 | Device capacity as log2 of MiB |
| out_valid | output | 1 | An address byte is offered |
| out_ready | input | 1 | The issuer accepts the offered byte |
| out_byte | output | 8 | Address byte |
| out_last | output | 1 | The offered byte is the final one |
| done | output | 1 | One-cycle end-of-series pulse |

## Verification
The assertions take for granted that `start` is a single-cycle pulse. They also assume that no new series is launched in the same cycle in which `done` is reported. Without these two conditions, a valid byte and a done pulse could legally overlap. The stimulus drives `start` for one cycle only, and it launches the next request only after it has seen `done`. The one exception is the deliberate mid-series start, which the block must ignore. Back-pressure comes from a pseudo-random ready pattern, so the assertions on holding the byte and advancing it are exercised over long stalls.

// File: rtl/nas_pkg.sv
package nas_pkg;
  parameter int unsigned CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/nas_plan.sv
module nas_plan
  import nas_pkg::*;
#(
  parameter int unsigned LG_W      = 4,
  parameter int unsigned LARGE_THR = 8,
  parameter int unsigned SMALL_THR = 6
) (
  input  logic            col_en,
  input  logic            page_en,
  input  logic            large_page,
  input  logic [LG_W-1:0] dev_log2_mib,
  output cnt_t            n_col,
  output cnt_t            n_row
);
  logic deep;

  always_comb begin
    deep  = large_page ? (32'(dev_log2_mib) >= LARGE_THR)
                       : (32'(dev_log2_mib) >= SMALL_THR);
    n_col = !col_en  ? cnt_t'(0) : (large_page ? cnt_t'(2) : cnt_t'(1));
    n_row = !page_en ? cnt_t'(0) : (deep       ? cnt_t'(3) : cnt_t'(2));
  end
endmodule

// File: rtl/nas_emit.sv
module nas_emit
  import nas_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 3,
  localparam int unsigned ROW_W    = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cnt_t             n_col,
  input  cnt_t             n_row,
  input  logic [ROW_W-1:0] page_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             done
);
  logic             busy_q, done_q;
  cnt_t             col_left, row_left;
  logic [ROW_W-1:0] shift_q;
  logic             fire, launch, empty_req;

  assign launch    = start && !busy_q;
  assign empty_req = (n_col == '0) && (n_row == '0);
  assign fire      = busy_q && out_ready;
  assign out_valid = busy_q;
  assign out_byte  = (col_left != '0) ? 8'h00 : shift_q[7:0];
  assign out_last  = busy_q && ((col_left + row_left) == cnt_t'(1));
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      col_left <= '0;
      row_left <= '0;
      shift_q  <= '0;
    end else begin
      done_q <= (fire && out_last) || (launch && empty_req);
      if (launch && !empty_req) begin
        busy_q   <= 1'b1;
        col_left <= n_col;
        row_left <= n_row;
        shift_q  <= page_addr;
      end else if (fire) begin
        if (col_left != '0) begin
          col_left <= col_left - cnt_t'(1);
        end else begin
          row_left <= row_left - cnt_t'(1);
          shift_q  <= shift_q >> 8;
        end
        if (out_last) busy_q <= 1'b0;
      end
    end
  end

  assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  assert_last_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start && !out_ready) |=> out_valid);

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 3,
  parameter int unsigned LG_W      = 4,
  parameter int unsigned LARGE_THR = 8,
  parameter int unsigned SMALL_THR = 6,
  localparam int unsigned ROW_W    = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             col_en,
  input  logic             page_en,
  input  logic [ROW_W-1:0] page_addr,
  input  logic             large_page,
  input  logic [LG_W-1:0]  dev_log2_mib,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             done
);
  cnt_t n_col, n_row;

  nas_plan #(.LG_W(LG_W), .LARGE_THR(LARGE_THR), .SMALL_THR(SMALL_THR)) u_plan (
    .col_en(col_en), .page_en(page_en), .large_page(large_page),
    .dev_log2_mib(dev_log2_mib), .n_col(n_col), .n_row(n_row)
  );

  nas_emit #(.ROW_BYTES(ROW_BYTES)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(start), .n_col(n_col), .n_row(n_row),
    .page_addr(page_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .done(done)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !done));
endmodule

// File: tb/nand_addr_seq_bench.sv
module nand_addr_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        col_en = 1'b0, page_en = 1'b0, large_page = 1'b0, out_ready = 1'b0;
  logic [23:0] page_addr = '0;
  logic [3:0]  dev_log2_mib = '0;
  logic        out_valid, out_last, done;
  logic [7:0]  out_byte;

  int errors = 0, checks = 0, n_done = 0;
  logic [8:0] exp_q[$];
  string cur_tag = "R10";
  logic due = 1'b0;
  bit   stall = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  nand_addr_seq u_nand_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .col_en(col_en), .page_en(page_en),
    .page_addr(page_addr), .large_page(large_page), .dev_log2_mib(dev_log2_mib),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .done(done)
  );

  // Monitor: scoreboard pop/compare and done timing (R8, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (due || done) begin
        checks++;
        if (done !== due) begin
          errors++;
          $display("FAIL R8 %s done: actual=%0b expected=%0b", cur_tag, done, due);
        end
      end
      if (done) n_done++;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6 %s extra byte: actual=%h expected=none", cur_tag, out_byte);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if ({out_last, out_byte} !== e) begin
            errors++;
            $display("FAIL %s byte/last: actual=%b_%h expected=%b_%h",
                     cur_tag, out_last, out_byte, e[8], e[7:0]);
          end
        end
      end
      due = (out_valid && out_ready && out_last) ||
            (start && !out_valid && !col_en && !page_en);
    end
  end

  // Ready pattern: free-flowing, or pseudo-random stalls
  always @(posedge clk) begin
    #1 out_ready <= stall ? (($urandom % 3) == 0) : 1'b1;
  end

  task automatic run(input string tag, input bit c, input bit p, input bit lg,
                     input int lgm, input logic [23:0] a, input bit poke);
    int nc, nr, tot, prev;
    nc  = c ? (lg ? 2 : 1) : 0;
    nr  = p ? ((lg ? (lgm >= 8) : (lgm >= 6)) ? 3 : 2) : 0;
    tot = nc + nr;
    for (int i = 0; i < tot; i++) begin
      logic [7:0] b;
      b = (i < nc) ? 8'h00 : a[8*(i-nc) +: 8];
      exp_q.push_back({(i == tot-1), b});
    end
    prev = n_done;
    @(posedge clk); #1;
    cur_tag = tag;
    col_en = c; page_en = p; large_page = lg; dev_log2_mib = 4'(lgm); page_addr = a;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R9: new request mid-series must be ignored
      col_en = 1'b0; page_en = 1'b1; large_page = 1'b1; page_addr = 24'hFFFFFF;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (n_done == prev) @(posedge clk);
    @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing bytes: actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual=%b%b expected=00", out_valid, done);
    end
    #1 rst_n = 1'b1;
    run("R1_R4", 1, 1, 0, 5, 24'h123456, 0);  // small page, 2 rows
    run("R4",    1, 1, 0, 6, 24'hABCDEF, 0);  // small page, 3 rows
    run("R3",    1, 1, 1, 7, 24'h0A0B0C, 0);  // large, 2 rows
    run("R3_R1", 1, 1, 1, 8, 24'h998877, 0);  // large, 3 rows
    run("R5",    1, 0, 0, 9, 24'h000000, 0);  // column only
    run("R5_R1", 1, 0, 1, 2, 24'h000000, 0);
    run("R2",    0, 1, 1, 9, 24'hC3B2A1, 0);
    run("R7",    0, 0, 1, 9, 24'h777777, 0);
    stall = 1'b1;
    for (int k = 0; k < 12; k++)
      run("R6", 1, 1, k[0], 4 + k/2, 24'(32'h5A0000 + k * 32'h10305), 0);
    run("R9", 1, 1, 0, 7, 24'h314159, 1);
    stall = 1'b0;
    run("R9", 1, 1, 1, 9, 24'h271828, 1);
    run("R7", 0, 0, 0, 0, 24'h000000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule